// File: doc/BRIEF.md
# Nested-Loop DMA Transfer Sequencer

This block is a single-channel transfer engine. It is programmed from a set of descriptor inputs that define two nested loops. The inner (minor) loop moves a fixed number of bytes as a run of equal-sized elements. Each element is read from a source address and then written to a destination address. The outer (major) loop counts how many minor loops remain. Every activation strobe runs exactly one minor loop, after which the engine goes idle. The major count then steps down by one.

When the final minor loop of a major pass finishes, the engine does four things. It sets a sticky done flag and reloads the major count from its start value. It pulses a link request so that a neighbouring channel can be triggered, which allows continual chained transfers. It raises a completion interrupt if that is enabled. Two kinds of error end a transfer with a sticky error flag and no done: a descriptor that is inconsistent, and an error reported by the memory. Software may cancel a running minor loop, and the cancel takes effect at the next element boundary.

Top module: `nested_xfer_seq`

## Requirements
- R1: One minor loop performs cfgMinorBytes / element-size elements. Each element is a read at the current source address followed by a write of exactly the data read to the current destination address. After every element, both addresses advance by their own signed 16-bit step, which is sign-extended to the address width.
- R2: A minor loop starts only on an activate strobe seen while idle. When the loop ends the engine stays idle until the next activate, and an activate while busy is ignored.
- R3: majorCount drops by one at the end of each completed minor loop. When it reaches zero it is reloaded from the start count latched by the last load, so a start count of 1 reads back 1 after every loop.
- R4: cfgSizeSel is a 2-bit code for the element size: 0 means 1 byte, 1 means 2 bytes, 2 means 4 bytes and 3 means 8 bytes. The code latched at activation is driven on memSize for every access of that loop.
- R5: Completion of the major loop does three things. It sets doneFlag, which stays set until the next load or accepted activation. It pulses linkReq high for exactly one cycle. It drives irqDone = doneFlag AND cfgIntEn.
- R6: An activation is rejected without any memory access, and errFlag is set, in any of these cases: cfgMinorBytes is zero, cfgMinorBytes is not a multiple of the element size, or majorCount is zero.
- R7: A memory acknowledge that arrives together with memErr stops the loop at once. It sets errFlag, and it leaves majorCount and doneFlag unchanged. irqErr = errFlag AND cfgErrIntEn. While errFlag is set, activate is ignored.
- R8: A cancel while busy stops the loop after the write of the element in progress. The partial loop does not decrement majorCount and does not set doneFlag or pulse linkReq. If that element is the last one of the minor loop, the loop completes normally.
- R9: cfgLoad while idle latches both addresses, sets majorCount to cfgMajorStart and clears doneFlag and errFlag. cfgLoad while busy is ignored.
- R10: After reset the engine is idle, with no memory request, doneFlag, errFlag and linkReq low, and majorCount zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgSrcAddr | input | 32 | Source start address |
| cfgDstAddr | input | 32 | Destination start address |
| cfgSrcStep | input | 16 | Signed source step per element |
| cfgDstStep | input | 16 | Signed destination step per element |
| cfgSizeSel | input | 2 | Element size code |
| cfgMinorBytes | input | 12 | Bytes per minor loop |
| cfgMajorStart | input | 10 | Major iteration start count |
| cfgIntEn | input | 1 | Completion interrupt enable |
| cfgErrIntEn | input | 1 | Error interrupt enable |
| cfgLoad | input | 1 | Load descriptor strobe |
| activate | input | 1 | Run one minor loop |
| cancel | input | 1 | Stop at next element boundary |
| memRdReq | output | 1 | Read request |
| memRdAddr | output | 32 | Read address |
| memRdAck | input | 1 | Read acknowledge, data valid |
| memRdData | input | 64 | Read data |
| memWrReq | output | 1 | Write request |
| memWrAddr | output | 32 | Write address |
| memWrData | output | 64 | Write data |
| memWrAck | input | 1 | Write acknowledge |
| memSize | output | 2 | Element size code of the access |
| memErr | input | 1 | Error, qualified by an acknowledge |
| busy | output | 1 | Minor loop in progress |
| majorCount | output | 10 | Current major iteration count |
| doneFlag | output | 1 | Major loop completed |
| errFlag | output | 1 | Transfer ended in error |
| linkReq | output | 1 | One-cycle link activation request |
| irqDone | output | 1 | Completion interrupt |
| irqErr | output | 1 | Error interrupt |

## Verification
A cancel and the end of the major loop can fall on the same element boundary. The bench provokes this by holding cancel high across the only element of a one-element, one-iteration descriptor. Completion must win: doneFlag is set, exactly one linkReq pulse is counted and majorCount is reloaded. A second case asserts cancel in the first element of a multi-element loop, and the bench checks that exactly one write happened, that majorCount did not move and that no link pulse occurred.

// File: rtl/nxfer_pkg.sv
package nxfer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadDesc;
    logic startMinor;
    logic latchData;
    logic stepElem;
    logic endMinor;
  } pathCtl_t;
endpackage

// File: rtl/nxfer_path.sv
module nxfer_path
  import nxfer_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 64,
  parameter int BYTES_W = 12,
  parameter int ITER_W  = 10,
  parameter int STEP_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  pathCtl_t           ctl,
  input  logic [ADDR_W-1:0]  cfgSrcAddr,
  input  logic [ADDR_W-1:0]  cfgDstAddr,
  input  logic [STEP_W-1:0]  cfgSrcStep,
  input  logic [STEP_W-1:0]  cfgDstStep,
  input  logic [1:0]         cfgSizeSel,
  input  logic [BYTES_W-1:0] cfgMinorBytes,
  input  logic [ITER_W-1:0]  cfgMajorStart,
  input  logic [DATA_W-1:0]  memRdData,
  output logic [ADDR_W-1:0]  srcAddr,
  output logic [ADDR_W-1:0]  dstAddr,
  output logic [1:0]         sizeQ,
  output logic [DATA_W-1:0]  wrData,
  output logic [ITER_W-1:0]  majorCount,
  output logic               cfgOk,
  output logic               lastElem,
  output logic               majorLast
);
  localparam int EXT_W = ADDR_W - STEP_W;
  localparam int NCH   = 2;

  logic [BYTES_W-1:0] bytesLeft;
  logic [BYTES_W-1:0] elemBytes;
  logic [BYTES_W-1:0] cfgElem;
  logic [ITER_W-1:0]  majorStartQ;
  logic [ADDR_W-1:0]  chanBase [NCH];
  logic [ADDR_W-1:0]  chanStep [NCH];
  logic [ADDR_W-1:0]  chanAddr [NCH];

  assign elemBytes = BYTES_W'(1) << sizeQ;
  assign cfgElem   = BYTES_W'(1) << cfgSizeSel;
  assign cfgOk     = (cfgMinorBytes != '0)
                   && ((cfgMinorBytes & (cfgElem - BYTES_W'(1))) == '0)
                   && (majorCount != '0);
  assign lastElem  = (bytesLeft == elemBytes);
  assign majorLast = (majorCount == ITER_W'(1));

  assign chanBase[0] = cfgSrcAddr;
  assign chanBase[1] = cfgDstAddr;
  assign chanStep[0] = {{EXT_W{cfgSrcStep[STEP_W-1]}}, cfgSrcStep};
  assign chanStep[1] = {{EXT_W{cfgDstStep[STEP_W-1]}}, cfgDstStep};

  // one address register per direction
  for (genvar gi = 0; gi < NCH; gi++) begin : g_addr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             chanAddr[gi] <= '0;
      else if (ctl.loadDesc) chanAddr[gi] <= chanBase[gi];
      else if (ctl.stepElem) chanAddr[gi] <= chanAddr[gi] + chanStep[gi];
    end
  end

  assign srcAddr = chanAddr[0];
  assign dstAddr = chanAddr[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bytesLeft   <= '0;
      sizeQ       <= '0;
      wrData      <= '0;
      majorCount  <= '0;
      majorStartQ <= '0;
    end else begin
      if (ctl.loadDesc) begin
        majorCount  <= cfgMajorStart;
        majorStartQ <= cfgMajorStart;
      end else if (ctl.endMinor) begin
        majorCount <= majorLast ? majorStartQ : majorCount - ITER_W'(1);
      end
      if (ctl.startMinor) begin
        bytesLeft <= cfgMinorBytes;
        sizeQ     <= cfgSizeSel;
      end else if (ctl.stepElem) begin
        bytesLeft <= bytesLeft - elemBytes;
      end
      if (ctl.latchData) wrData <= memRdData;
    end
  end

  // R1: an element step never takes more bytes than remain
  a_r1_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    ctl.stepElem |-> (bytesLeft >= elemBytes));
  // R3: a running loop always has a live major count
  a_r3_major_live: assert property (@(posedge clk) disable iff (!rstN)
    ctl.stepElem |-> (majorCount != '0));
endmodule

// File: rtl/nxfer_ctrl.sv
module nxfer_ctrl
  import nxfer_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     activate,
  input  logic     cancel,
  input  logic     cfgLoad,
  input  logic     memRdAck,
  input  logic     memWrAck,
  input  logic     memErr,
  input  logic     cfgOk,
  input  logic     lastElem,
  input  logic     majorLast,
  output pathCtl_t ctl,
  output logic     memRdReq,
  output logic     memWrReq,
  output logic     busy,
  output logic     doneFlag,
  output logic     errFlag,
  output logic     linkReq
);
  seqState_t st, stNext;
  logic cancelPend;
  logic cfgFault, memFault, finish;

  always_comb begin
    ctl    = '0;
    stNext = st;
    unique case (st)
      ST_IDLE: begin
        if (cfgLoad) begin
          ctl.loadDesc = 1'b1;
        end else if (activate && !errFlag && cfgOk) begin
          ctl.startMinor = 1'b1;
          stNext = ST_READ;
        end
      end
      ST_READ: begin
        if (memRdAck) begin
          if (memErr) stNext = ST_IDLE;
          else begin
            ctl.latchData = 1'b1;
            stNext = ST_WRITE;
          end
        end
      end
      ST_WRITE: begin
        if (memWrAck) begin
          if (memErr) stNext = ST_IDLE;
          else begin
            ctl.stepElem = 1'b1;
            if (lastElem) begin
              ctl.endMinor = 1'b1;
              stNext = ST_IDLE;
            end else if (cancelPend || cancel) begin
              stNext = ST_IDLE;
            end else begin
              stNext = ST_READ;
            end
          end
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  assign cfgFault = (st == ST_IDLE) && !cfgLoad && activate && !errFlag && !cfgOk;
  assign memFault = memErr && (((st == ST_READ) && memRdAck) || ((st == ST_WRITE) && memWrAck));
  assign finish   = ctl.endMinor && majorLast;

  assign memRdReq = (st == ST_READ);
  assign memWrReq = (st == ST_WRITE);
  assign busy     = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st         <= ST_IDLE;
      cancelPend <= 1'b0;
      doneFlag   <= 1'b0;
      errFlag    <= 1'b0;
      linkReq    <= 1'b0;
    end else begin
      st         <= stNext;
      cancelPend <= (stNext != ST_IDLE) && (cancelPend || (cancel && busy));
      linkReq    <= finish;
      if (ctl.loadDesc)              errFlag <= 1'b0;
      else if (cfgFault || memFault) errFlag <= 1'b1;
      if (ctl.loadDesc || ctl.startMinor) doneFlag <= 1'b0;
      else if (finish)                    doneFlag <= 1'b1;
    end
  end

  // R2: idle persists without an activate
  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_IDLE && !activate) |=> (st == ST_IDLE));
  // R5: link request is a single-cycle pulse
  a_r5_link_pulse: assert property (@(posedge clk) disable iff (!rstN)
    linkReq |=> !linkReq);
  // R5: a link pulse comes with the done flag
  a_r5_done_with_link: assert property (@(posedge clk) disable iff (!rstN)
    linkReq |-> doneFlag);
  // R7: an errored channel never links
  a_r7_err_no_link: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> !linkReq);
endmodule

// File: rtl/nested_xfer_seq.sv
module nested_xfer_seq
  import nxfer_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 64,
  parameter int BYTES_W = 12,
  parameter int ITER_W  = 10,
  parameter int STEP_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  cfgSrcAddr,
  input  logic [ADDR_W-1:0]  cfgDstAddr,
  input  logic [STEP_W-1:0]  cfgSrcStep,
  input  logic [STEP_W-1:0]  cfgDstStep,
  input  logic [1:0]         cfgSizeSel,
  input  logic [BYTES_W-1:0] cfgMinorBytes,
  input  logic [ITER_W-1:0]  cfgMajorStart,
  input  logic               cfgIntEn,
  input  logic               cfgErrIntEn,
  input  logic               cfgLoad,
  input  logic               activate,
  input  logic               cancel,
  output logic               memRdReq,
  output logic [ADDR_W-1:0]  memRdAddr,
  input  logic               memRdAck,
  input  logic [DATA_W-1:0]  memRdData,
  output logic               memWrReq,
  output logic [ADDR_W-1:0]  memWrAddr,
  output logic [DATA_W-1:0]  memWrData,
  input  logic               memWrAck,
  output logic [1:0]         memSize,
  input  logic               memErr,
  output logic               busy,
  output logic [ITER_W-1:0]  majorCount,
  output logic               doneFlag,
  output logic               errFlag,
  output logic               linkReq,
  output logic               irqDone,
  output logic               irqErr
);
  pathCtl_t ctl;
  logic cfgOk, lastElem, majorLast;

  nxfer_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .activate  (activate),
    .cancel    (cancel),
    .cfgLoad   (cfgLoad),
    .memRdAck  (memRdAck),
    .memWrAck  (memWrAck),
    .memErr    (memErr),
    .cfgOk     (cfgOk),
    .lastElem  (lastElem),
    .majorLast (majorLast),
    .ctl       (ctl),
    .memRdReq  (memRdReq),
    .memWrReq  (memWrReq),
    .busy      (busy),
    .doneFlag  (doneFlag),
    .errFlag   (errFlag),
    .linkReq   (linkReq)
  );

  nxfer_path #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .BYTES_W (BYTES_W),
    .ITER_W (ITER_W), .STEP_W (STEP_W)
  ) i_path (
    .clk           (clk),
    .rstN          (rstN),
    .ctl           (ctl),
    .cfgSrcAddr    (cfgSrcAddr),
    .cfgDstAddr    (cfgDstAddr),
    .cfgSrcStep    (cfgSrcStep),
    .cfgDstStep    (cfgDstStep),
    .cfgSizeSel    (cfgSizeSel),
    .cfgMinorBytes (cfgMinorBytes),
    .cfgMajorStart (cfgMajorStart),
    .memRdData     (memRdData),
    .srcAddr       (memRdAddr),
    .dstAddr       (memWrAddr),
    .sizeQ         (memSize),
    .wrData        (memWrData),
    .majorCount    (majorCount),
    .cfgOk         (cfgOk),
    .lastElem      (lastElem),
    .majorLast     (majorLast)
  );

  assign irqDone = doneFlag & cfgIntEn;
  assign irqErr  = errFlag & cfgErrIntEn;
endmodule

// File: tb/test_nested_xfer_seq.sv
`timescale 1ns/1ps
module test_nested_xfer_seq;
  localparam logic [31:0] SRC0 = 32'h0000_1000;
  localparam logic [31:0] DST0 = 32'h0000_8000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] cfgSrcAddr = SRC0, cfgDstAddr = DST0;
  logic [15:0] cfgSrcStep = '0, cfgDstStep = '0;
  logic [1:0]  cfgSizeSel = '0;
  logic [11:0] cfgMinorBytes = '0;
  logic [9:0]  cfgMajorStart = '0;
  logic cfgIntEn = 1'b0, cfgErrIntEn = 1'b0, cfgLoad = 1'b0;
  logic activate = 1'b0, cancel = 1'b0;
  logic memRdReq, memWrReq, memRdAck = 1'b0, memWrAck = 1'b0, memErr = 1'b0;
  logic [31:0] memRdAddr, memWrAddr;
  logic [63:0] memRdData = '0, memWrData;
  logic [1:0]  memSize;
  logic busy, doneFlag, errFlag, linkReq, irqDone, irqErr;
  logic [9:0] majorCount;

  // bench memory model state
  int wrCount = 0, linkCount = 0;
  logic [31:0] lastRdAddr = '0, lastWrAddr = '0;
  logic [63:0] lastWrData = '0;
  logic [1:0]  lastSize = '0;
  logic errArm = 1'b0;
  logic [31:0] errAddr = '0;

  int total = 0, bad = 0;

  always #2 clk = ~clk;

  nested_xfer_seq i_nested_xfer_seq (
    .clk(clk), .rstN(rstN),
    .cfgSrcAddr(cfgSrcAddr), .cfgDstAddr(cfgDstAddr),
    .cfgSrcStep(cfgSrcStep), .cfgDstStep(cfgDstStep),
    .cfgSizeSel(cfgSizeSel), .cfgMinorBytes(cfgMinorBytes),
    .cfgMajorStart(cfgMajorStart), .cfgIntEn(cfgIntEn),
    .cfgErrIntEn(cfgErrIntEn), .cfgLoad(cfgLoad),
    .activate(activate), .cancel(cancel),
    .memRdReq(memRdReq), .memRdAddr(memRdAddr), .memRdAck(memRdAck),
    .memRdData(memRdData), .memWrReq(memWrReq), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .memWrAck(memWrAck), .memSize(memSize),
    .memErr(memErr), .busy(busy), .majorCount(majorCount),
    .doneFlag(doneFlag), .errFlag(errFlag), .linkReq(linkReq),
    .irqDone(irqDone), .irqErr(irqErr)
  );

  function automatic logic [63:0] rdFunc(logic [31:0] a);
    return {a ^ 32'h5A5A_0F0F, a};
  endfunction

  // memory responder: acknowledges every request at the next falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (linkReq) linkCount = linkCount + 1;
      memRdAck  = memRdReq;
      memWrAck  = memWrReq;
      memErr    = memRdReq && errArm && (memRdAddr == errAddr);
      memRdData = rdFunc(memRdAddr);
      if (memRdReq) lastRdAddr = memRdAddr;
      if (memWrReq) begin
        wrCount    = wrCount + 1;
        lastWrAddr = memWrAddr;
        lastWrData = memWrData;
        lastSize   = memSize;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic loadDesc(input logic [1:0] sz, input int minor, input int start,
                          input int sstep, input int dstep);
    @(negedge clk);
    cfgSizeSel = sz; cfgMinorBytes = 12'(minor); cfgMajorStart = 10'(start);
    cfgSrcStep = 16'(sstep); cfgDstStep = 16'(dstep);
    cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
  endtask

  task automatic kick();
    @(negedge clk); activate = 1'b1;
    @(negedge clk); activate = 1'b0;
  endtask

  task automatic waitIdle();
    int n = 0;
    do begin
      @(negedge clk); #1; n++;
    end while (busy && n < 2000);
    repeat (2) @(negedge clk);
    #1;
  endtask

  typedef struct packed {
    logic [1:0]  sz;
    logic [11:0] minor;
    logic [9:0]  start;
    logic [15:0] sstep;
    logic [15:0] dstep;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd0, 12'd5,  10'd3, 16'd1,     16'd1},
    '{2'd1, 12'd8,  10'd2, 16'd2,     16'hFFFE},
    '{2'd2, 12'd16, 10'd1, 16'd4,     16'd4},
    '{2'd3, 12'd24, 10'd2, 16'd8,     16'hFFF8},
    '{2'd2, 12'd4,  10'd1, 16'hFFFC,  16'd12},
    '{2'd0, 12'd1,  10'd1, 16'd0,     16'd1}
  };

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    bad = bad + 1; total = total + 1;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w0, l0, n;
    logic [31:0] expAddr;
    repeat (3) @(negedge clk);
    #1;
    // R10 reset state
    check(!busy && !memRdReq && !memWrReq, "R10 idle after reset", {62'd0, busy, memRdReq}, 64'd0);
    check(!doneFlag && !errFlag && !linkReq, "R10 flags clear", {61'd0, doneFlag, errFlag, linkReq}, 64'd0);
    check(majorCount == 0, "R10 major count zero", 64'(majorCount), 64'd0);
    rstN = 1'b1;
    cfgIntEn = 1'b1; cfgErrIntEn = 1'b1;

    // table of vectors, one minor loop each
    for (int i = 0; i < 6; i++) begin
      loadDesc(VECS[i].sz, int'(VECS[i].minor), int'(VECS[i].start),
               int'($signed(VECS[i].sstep)), int'($signed(VECS[i].dstep)));
      w0 = wrCount;
      kick();
      waitIdle();
      n = int'(VECS[i].minor) >> VECS[i].sz;
      expAddr = DST0 + 32'((n - 1) * int'($signed(VECS[i].dstep)));
      check(wrCount - w0 == n, $sformatf("R1 element count v%0d", i), 64'(wrCount - w0), 64'(n));
      check(lastWrAddr == expAddr, $sformatf("R1 last write address v%0d", i), 64'(lastWrAddr), 64'(expAddr));
      check(lastWrData == rdFunc(lastRdAddr), $sformatf("R1 write data v%0d", i), lastWrData, rdFunc(lastRdAddr));
      check(lastSize == VECS[i].sz, $sformatf("R4 size code v%0d", i), 64'(lastSize), 64'(VECS[i].sz));
      check(majorCount == ((VECS[i].start == 1) ? 10'd1 : VECS[i].start - 10'd1),
            $sformatf("R3 major count v%0d", i), 64'(majorCount), 64'(VECS[i].start));
      check(doneFlag == (VECS[i].start == 1), $sformatf("R5 done flag v%0d", i), 64'(doneFlag), 64'(VECS[i].start == 1));
    end

    // R2: no self start, activate while busy ignored
    loadDesc(2'd0, 4, 3, 1, 1);
    w0 = wrCount;
    kick();
    @(negedge clk); activate = 1'b1;
    @(negedge clk); activate = 1'b0;
    waitIdle();
    repeat (10) @(negedge clk);
    #1;
    check(wrCount - w0 == 4, "R2 one loop per activation", 64'(wrCount - w0), 64'd4);
    check(majorCount == 2, "R2 single decrement", 64'(majorCount), 64'd2);

    // R3/R5: full major pass with start 2
    loadDesc(2'd1, 4, 2, 2, 2);
    l0 = linkCount;
    kick(); waitIdle();
    check(majorCount == 1 && !doneFlag, "R3 first pass not done", 64'(majorCount), 64'd1);
    kick(); waitIdle();
    check(linkCount - l0 == 1, "R5 one link pulse", 64'(linkCount - l0), 64'd1);
    check(irqDone == 1'b1, "R5 completion interrupt", 64'(irqDone), 64'd1);
    check(majorCount == 2, "R3 reload after completion", 64'(majorCount), 64'd2);
    @(negedge clk); cfgIntEn = 1'b0; #1;
    check(irqDone == 1'b0 && doneFlag, "R5 interrupt gated by enable", 64'(irqDone), 64'd0);
    cfgIntEn = 1'b1;

    // R6: misaligned byte count
    loadDesc(2'd2, 6, 2, 4, 4);
    w0 = wrCount;
    kick(); waitIdle();
    check(errFlag && wrCount == w0, "R6 misaligned rejected", {63'd0, errFlag}, 64'd1);
    check(irqErr == 1'b1 && !doneFlag, "R6 error interrupt", 64'(irqErr), 64'd1);
    kick(); waitIdle();
    check(wrCount == w0, "R7 activate ignored while errored", 64'(wrCount - w0), 64'd0);
    loadDesc(2'd0, 0, 2, 1, 1);
    check(!errFlag, "R9 load clears error", 64'(errFlag), 64'd0);
    kick(); waitIdle();
    check(errFlag && wrCount == w0, "R6 zero byte count rejected", {63'd0, errFlag}, 64'd1);

    // R7: memory error on third read
    loadDesc(2'd0, 8, 2, 1, 1);
    errAddr = SRC0 + 32'd2; errArm = 1'b1;
    w0 = wrCount;
    kick(); waitIdle();
    errArm = 1'b0;
    check(wrCount - w0 == 2, "R7 stops at faulting element", 64'(wrCount - w0), 64'd2);
    check(errFlag && !doneFlag && majorCount == 2, "R7 error without decrement", 64'(majorCount), 64'd2);
    @(negedge clk); cfgErrIntEn = 1'b0; #1;
    check(irqErr == 1'b0, "R7 error interrupt gated", 64'(irqErr), 64'd0);
    cfgErrIntEn = 1'b1;

    // R8: cancel in the first element of a long loop
    loadDesc(2'd0, 8, 2, 1, 1);
    w0 = wrCount; l0 = linkCount;
    kick();
    cancel = 1'b1;
    @(negedge clk); cancel = 1'b0;
    waitIdle();
    check(wrCount - w0 == 1, "R8 stops after current element", 64'(wrCount - w0), 64'd1);
    check(majorCount == 2 && !doneFlag && linkCount == l0, "R8 no decrement no link", 64'(majorCount), 64'd2);

    // R8: cancel coinciding with completion of the major loop
    loadDesc(2'd0, 1, 1, 1, 1);
    w0 = wrCount; l0 = linkCount;
    kick();
    cancel = 1'b1;
    repeat (2) @(negedge clk);
    cancel = 1'b0;
    waitIdle();
    check(doneFlag && linkCount - l0 == 1, "R8 completion wins over cancel", 64'(linkCount - l0), 64'd1);
    check(wrCount - w0 == 1 && majorCount == 1, "R8 final element written", 64'(wrCount - w0), 64'd1);

    // R9: load while busy ignored
    loadDesc(2'd0, 4, 3, 1, 1);
    kick();
    @(negedge clk); cfgMajorStart = 10'd7; cfgLoad = 1'b1;
    @(negedge clk); cfgLoad = 1'b0;
    waitIdle();
    check(majorCount == 2, "R9 load ignored while busy", 64'(majorCount), 64'd2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule